// File: doc/BRIEF.md
# Framed Serial Wiper Control Receiver

This block is the serial slave front end of a 1024-step digital resistor controller. It runs entirely in the system clock domain. The frame strobe, serial clock and serial data pins each pass through a two-flop synchronizer and are then oversampled. While the active-low frame strobe is low, the block moves one data bit, MSB first, into a 16-bit shift register on each falling serial clock edge. When the strobe rises, the frame is accepted only if exactly sixteen falling edges were counted. A shorter frame or a longer one is dropped whole, so a partial value never reaches the wiper.

An accepted frame carries a header and a 10-bit data field. Bits 15:10 form the header: bits 15:14 must be zero and bits 13:10 hold the command. A write command loads the 10-bit wiper position and raises a one-cycle update strobe. A readback command copies the wiper into the shift register, so the next frame clocks it out. The serial output works as an open-drain pull-down. During a frame it presents the previous shift register contents MSB first, which allows daisy chaining as well as readback. The system clock must run at least four times as fast as the serial clock.

Top module: `serial_wiper_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, the wiper output is 512, the update strobe is low and the serial output is released (pull-down enable low).
- R2: While the frame strobe is low, one data bit is taken on each falling serial clock edge, MSB first, into a 16-bit frame. The frame layout is: bits 15:14 zero, bits 13:10 command, bits 9:0 data.
- R3: When the frame strobe rises after exactly 16 falling edges and bits 15:10 equal 6'b000001 (write), the wiper takes bits 9:0 and the update strobe is high for exactly one cycle.
- R4: A frame whose strobe rises after fewer than 16 falling edges changes nothing: no update strobe and no wiper change.
- R5: A frame with 17 or more falling edges changes nothing.
- R6: A header of 6'b000000 (no operation), a header holding any other command code, or a header with nonzero bits 15:14 leaves the wiper unchanged and raises no update strobe.
- R7: A header of 6'b000010 (readback) loads {6'b0, wiper} into the shift register. The next frame then presents those 16 bits on the serial output, MSB first.
- R8: In any other case, the serial output during a frame presents the 16 bits of the previous frame, MSB first. Bit k is valid before the k-th falling edge. The output is pulled low for a 0 bit, released for a 1 bit, and always released while the frame strobe is high.
- R9: Serial clock edges while the frame strobe is high leave the shift register untouched.
- R10: The wiper output changes only in a cycle where the update strobe is high, and every update strobe follows an accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sync_n_i | input | 1 | Active-low frame strobe pin, asynchronous |
| din_i | input | 1 | Serial data in, asynchronous |
| sdo_low_o | output | 1 | Open-drain serial out: 1 pulls the line low, 0 releases it |
| wiper_o | output | 10 | Wiper position register |
| update_o | output | 1 | One-cycle strobe when the wiper is written |

## Verification
The hardest cases to reach are the ones that change nothing visible on the wiper. Serial clock edges that arrive while the strobe is high can only be seen through the shift register. To expose that register, the bench follows such edges with a frame that shifts the old contents back out on the serial output and compares them bit by bit. Off-length frames use the same table as valid ones: 15 and 17 clock edges are driven with a write header, and each check confirms that the wiper still holds its earlier value. Readback is reached by a readback frame followed by a no-operation frame, whose serial output must equal the wiper.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP  = 4'd0,
    CMD_WR   = 4'd1,
    CMD_RDBK = 4'd2
  } cmd_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
    end else begin
      st[0] <= in_i;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign out_o = st[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               sync_n_s,
  input  logic               din_s,
  input  logic               load_en_i,
  input  logic [FRAME_W-1:0] load_val_i,
  output logic               commit_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sdo_low_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(FRAME_W);

  logic               sclk_d, sync_d;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic               sclk_fall, sync_fall, sync_rise;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign sync_fall = sync_d & ~sync_n_s;
  assign sync_rise = ~sync_d & sync_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      sync_d    <= 1'b1;
      cnt       <= '0;
      shreg     <= '0;
      commit_o  <= 1'b0;
      frame_o   <= '0;
      sdo_low_o <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      sync_d   <= sync_n_s;
      commit_o <= 1'b0;
      if (sync_fall) begin
        cnt <= '0;
      end else if (!sync_n_s && sclk_fall) begin
        shreg <= {shreg[FRAME_W-2:0], din_s};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (sync_rise && cnt == CNT_OK) begin
        commit_o <= 1'b1;
        frame_o  <= shreg;
      end
      if (load_en_i) shreg <= load_val_i;
      sdo_low_o <= !sync_n_s && !shreg[FRAME_W-1];
    end
  end
endmodule

// File: rtl/srx_decode.sv
module srx_decode
  import srx_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int WIPER_W = 10,
  parameter int RESET_POS = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               update_o,
  output logic               load_en_o,
  output logic [FRAME_W-1:0] load_val_o
);
  localparam int HDR_W = FRAME_W - WIPER_W;

  logic [HDR_W-1:0]   hdr;
  logic [WIPER_W-1:0] data;

  assign hdr  = frame_i[FRAME_W-1 -: HDR_W];
  assign data = frame_i[WIPER_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper_o   <= WIPER_W'(RESET_POS);
      update_o  <= 1'b0;
      load_en_o <= 1'b0;
    end else begin
      update_o  <= 1'b0;
      load_en_o <= 1'b0;
      if (commit_i) begin
        if (hdr == HDR_W'(CMD_WR)) begin
          wiper_o  <= data;
          update_o <= 1'b1;
        end else if (hdr == HDR_W'(CMD_RDBK)) begin
          load_en_o <= 1'b1;
        end
      end
    end
  end

  assign load_val_o = FRAME_W'(wiper_o);
endmodule

// File: rtl/serial_wiper_rx.sv
module serial_wiper_rx #(
  parameter int FRAME_W = 16,
  parameter int WIPER_W = 10,
  parameter int SYNC_STAGES = 2,
  parameter int RESET_POS = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_i,
  input  logic               sync_n_i,
  input  logic               din_i,
  output logic               sdo_low_o,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               update_o
);
  logic               sclk_s, sync_n_s, din_s;
  logic               commit, load_en;
  logic [FRAME_W-1:0] frame, load_val;

  srx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .in_i({sync_n_i, sclk_i, din_i}),
    .out_o({sync_n_s, sclk_s, din_s})
  );

  srx_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_s(sclk_s), .sync_n_s(sync_n_s), .din_s(din_s),
    .load_en_i(load_en), .load_val_i(load_val),
    .commit_o(commit), .frame_o(frame), .sdo_low_o(sdo_low_o)
  );

  srx_decode #(.FRAME_W(FRAME_W), .WIPER_W(WIPER_W), .RESET_POS(RESET_POS)) u_dec (
    .clk(clk), .rst(rst),
    .commit_i(commit), .frame_i(frame),
    .wiper_o(wiper_o), .update_o(update_o),
    .load_en_o(load_en), .load_val_o(load_val)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int WIPER_W = 10,
  parameter int RESET_POS = 512
) (
  input logic               clk,
  input logic               rst,
  input logic               update,
  input logic [WIPER_W-1:0] wiper,
  input logic               sdo_low,
  input logic               sync_n_s,
  input logic               commit
);
  // R3: the update strobe lasts a single cycle
  assert_update_single_R3: assert property (@(posedge clk) disable iff (rst)
    update |=> !update);

  // R10: wiper moves only together with the update strobe
  assert_wiper_gated_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(wiper) |-> update);

  // R10: each update strobe follows an accepted frame
  assert_update_after_commit_R10: assert property (@(posedge clk) disable iff (rst)
    update |-> $past(commit));

  // R8: the pull-down is never active while the synchronized strobe was high
  assert_sdo_released_R8: assert property (@(posedge clk) disable iff (rst)
    sdo_low |-> !$past(sync_n_s));

  // R1: the first cycle after reset shows midscale and no strobe
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wiper == WIPER_W'(RESET_POS) && !update && !sdo_low));
endmodule

bind serial_wiper_rx srx_checker #(.WIPER_W(WIPER_W), .RESET_POS(RESET_POS)) u_chk (
  .clk(clk), .rst(rst), .update(update_o), .wiper(wiper_o),
  .sdo_low(sdo_low_o), .sync_n_s(sync_n_s), .commit(commit)
);

// File: tb/serial_wiper_rx_bench.sv
`timescale 1ns/1ps
module serial_wiper_rx_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sync_n = 1'b1, din = 1'b0;
  logic sdo_low, update;
  logic [9:0] wiper;

  int total = 0, bad = 0;
  int upd_cycles;
  logic [15:0] sdo_cap;

  always #2 clk = ~clk;

  serial_wiper_rx u_serial_wiper_rx (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sync_n_i(sync_n), .din_i(din),
    .sdo_low_o(sdo_low), .wiper_o(wiper), .update_o(update)
  );

  // {frame[15:0], falling edges[7:0], update expected[7:0], wiper expected[15:0]}
  localparam logic [47:0] VEC [10] = '{
    48'h07FF_10_01_03FF,  // R3 write 1023
    48'h0400_10_01_0000,  // R3 write 0
    48'h0555_10_01_0155,  // R2/R3 alternating data
    48'h0464_0F_00_0155,  // R4 15 edges
    48'h0478_11_00_0155,  // R5 17 edges
    48'h02AA_10_00_0155,  // R6 no operation
    48'h0C12_10_00_0155,  // R6 unknown command
    48'h8432_10_00_0155,  // R6 nonzero top bits
    48'h0600_10_01_0200,  // R3 write 512
    48'h0800_10_00_0200   // R7 readback
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] f, input int n);
    sync_n = 1'b0;
    wait_clk(8);
    for (int i = 0; i < n; i++) begin
      din = (i < 16) ? f[15-i] : 1'b0;
      sclk = 1'b1;
      wait_clk(4);
      if (i < 16) sdo_cap[15-i] = !sdo_low;
      sclk = 1'b0;
      wait_clk(4);
    end
    wait_clk(4);
    sync_n = 1'b1;
    upd_cycles = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (update) upd_cycles++;
    end
    wait_clk(4);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(5);
    check(wiper == 10'd512, "R1 reset wiper", wiper, 512);
    check(!update && !sdo_low, "R1 reset strobes", {update, sdo_low}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(wiper == 10'd512 && !update && !sdo_low, "R1 after reset", wiper, 512);
    wait_clk(4);

    foreach (VEC[k]) begin
      send_frame(VEC[k][47:32], int'(VEC[k][31:24]));
      check(upd_cycles == int'(VEC[k][23:16]), $sformatf("R3/R4/R5/R6 update count vec%0d", k),
            upd_cycles, int'(VEC[k][23:16]));
      check(wiper == VEC[k][9:0], $sformatf("R3/R4/R5/R6 wiper vec%0d", k),
            wiper, int'(VEC[k][9:0]));
    end

    // R7: the frame after the readback shows the wiper on the serial output
    send_frame(16'h0000, 16);
    check(sdo_cap == 16'h0200, "R7 readback contents", sdo_cap, 16'h0200);
    check(!sdo_low, "R8 released while strobe high", sdo_low, 0);

    // R8 daisy chain and R9 ignored edges while the strobe is high
    send_frame(16'h04A5, 16);
    check(wiper == 10'h0A5 && upd_cycles == 1, "R3 write 165", wiper, 165);
    din = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    check(!sdo_low, "R8 released during idle edges", sdo_low, 0);
    send_frame(16'h0000, 16);
    check(sdo_cap == 16'h04A5, "R8/R9 previous frame shifted out", sdo_cap, 16'h04A5);
    check(wiper == 10'h0A5 && upd_cycles == 0, "R6 no-op after daisy", wiper, 165);

    // R8: all-zero frame gives a pull-down on every bit of the next frame
    send_frame(16'h0000, 16);
    check(sdo_cap == 16'h0000, "R8 zeros pulled low", sdo_cap, 0);

    // R4: a frame aborted after a single edge
    send_frame(16'h07FF, 1);
    check(wiper == 10'h0A5 && upd_cycles == 0, "R4 single edge abort", wiper, 165);

    // R1: reset in the middle of operation
    @(negedge clk); rst = 1'b1;
    wait_clk(3);
    rst = 1'b0;
    @(negedge clk);
    check(wiper == 10'd512 && !update && !sdo_low, "R1 reset mid-run", wiper, 512);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule